// File: doc/BRIEF.md
# Third-Order Cascaded Error-Feedback Modulator

This block reduces a wide, oversampled signed PCM stream to a short signed multilevel code for a multibit DAC. It does so with three first-order error-feedback stages in cascade. Each stage adds the error it kept from the previous sample to its present input. It then truncates the sum toward minus infinity, keeping only the top bits. The discarded low bits become its error for the next sample, and they are also the input of the next stage.

A cancellation network combines the three stage codes as y1 + (1 − z⁻¹)·y2 + (1 − z⁻¹)²·y3. After that step only the third-stage error is left in the output, and it is shaped by (1 − z⁻¹)³. Every coefficient in the datapath is a shift or an add.

The block advances one sample per cycle in which the sample strobe is high. Between strobes it holds all of its state.

Top module: `mash3_shaper`

## Requirements
- R1: After synchronous reset, `code_out` is 0 and `code_vld` is 0, and every stored error and delay register is zero.
- R2: `code_vld` is high in exactly the cycle after a cycle with `smp_en` high, and low otherwise.
- R3: In a cycle with `smp_en` low, no state changes and `code_out` holds its value. Samples taken after a gap give the same results as if there had been no gap.
- R4: The first stage forms s1 = x + e1, using the stored first-stage error e1. Its code y1 = floor(s1 / 2^F), where F = IN_W − Q_W (21 by default). Its new e1 is the low F bits of s1, read as unsigned.
- R5: The second stage forms s2 = e1new + e2 and the third stage forms s3 = e2new + e3. Each is quantized the same way, giving codes y2 and y3 in {0, 1}.
- R6: `code_out` = y1[n] + y2[n] − y2[n−1] + y3[n] − 2·y3[n−1] + y3[n−2]. Here [n−k] counts strobed samples, and delayed values start at zero after reset.
- R7: Full-scale input (−2^23 and 2^23−1) gives the exact R6 value with no wrap. `code_out` always lies within ±(2^(Q_W−1)+3).
- R8: For a constant input x, the sum of N output codes times 2^F differs from N·x by at most 4·2^F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe; one sample is consumed per high cycle |
| pcm_in | input | IN_W (24) | Signed two's-complement input sample |
| code_out | output | Q_W+2 (5) | Signed multilevel output code |
| code_vld | output | 1 | Output code updated this cycle |

## Verification
The bench drives full-scale positive and negative inputs. A design that truncated toward zero, or that carried no guard bit in the accumulator, would give wrong codes at these inputs or wrap the sum. Irregular strobe gaps would expose any state that leaks forward while the strobe is low. Long constant-input runs check that the average of the output equals the input. They catch a wrong sign or a missing factor of two in the cancellation terms, which leaves a DC offset or noise that does not cancel. A stream of random and ramp samples is compared, sample by sample, against an arithmetic model.

// File: rtl/mash3_shaper.sv
module mash3_shaper #(
  parameter int IN_W = 24,
  parameter int Q_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_en,
  input  logic signed [IN_W-1:0]  pcm_in,
  output logic signed [Q_W+1:0]   code_out,
  output logic                    code_vld
);
  localparam int F     = IN_W - Q_W;
  localparam int W     = IN_W + 1;
  localparam int OUT_W = Q_W + 2;
  localparam int LIM   = (1 << (Q_W - 1)) + 3;

  logic        [F-1:0]   e1, e2, e3;
  logic signed [W-1:0]   s1, s2, s3;
  logic signed [Q_W:0]   y1, y2, y3, y2d, y3d1, y3d2;
  logic signed [OUT_W-1:0] sum;

  assign s1 = {pcm_in[IN_W-1], pcm_in} + W'(e1);
  assign s2 = W'(s1[F-1:0]) + W'(e2);
  assign s3 = W'(s2[F-1:0]) + W'(e3);
  assign y1 = s1[W-1:F];
  assign y2 = s2[W-1:F];
  assign y3 = s3[W-1:F];

  assign sum = OUT_W'(y1)
             + OUT_W'(y2) - OUT_W'(y2d)
             + OUT_W'(y3) - (OUT_W'(y3d1) <<< 1) + OUT_W'(y3d2);

  always_ff @(posedge clk) begin
    if (rst) begin
      e1 <= '0; e2 <= '0; e3 <= '0;
      y2d <= '0; y3d1 <= '0; y3d2 <= '0;
      code_out <= '0;
      code_vld <= 1'b0;
    end else begin
      code_vld <= smp_en;
      if (smp_en) begin
        e1 <= s1[F-1:0];
        e2 <= s2[F-1:0];
        e3 <= s3[F-1:0];
        y2d  <= y2;
        y3d1 <= y3;
        y3d2 <= y3d1;
        code_out <= sum;
      end
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (code_out == '0 && !code_vld));

  assert_vld_follows_en_R2: assert property (@(posedge clk) disable iff (rst)
    smp_en |=> code_vld);

  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> ($stable(code_out) && !code_vld));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    code_vld |-> (int'(code_out) <= LIM && int'(code_out) >= -LIM));

endmodule

// File: tb/mash3_shaper_tb.sv
module mash3_shaper_tb;
  localparam int IN_W = 24;
  localparam int Q_W  = 3;
  localparam int F    = IN_W - Q_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_en = 1'b0;
  logic signed [IN_W-1:0] pcm_in = '0;
  logic signed [Q_W+1:0] code_out;
  logic code_vld;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  longint m_e1, m_e2, m_e3, m_y2d, m_y3d1, m_y3d2, m_out;
  bit m_vld;

  always #2.5 clk = ~clk;

  mash3_shaper #(.IN_W(IN_W), .Q_W(Q_W)) u_dut (
    .clk(clk), .rst(rst), .smp_en(smp_en), .pcm_in(pcm_in),
    .code_out(code_out), .code_vld(code_vld));

  task automatic model_reset();
    m_e1 = 0; m_e2 = 0; m_e3 = 0;
    m_y2d = 0; m_y3d1 = 0; m_y3d2 = 0;
    m_out = 0; m_vld = 0;
  endtask

  task automatic model_step(input bit en, input longint x);
    longint s1, s2, s3, y1, y2, y3, mask;
    mask = (longint'(1) << F) - 1;
    m_vld = en;
    if (en) begin
      s1 = x + m_e1;     y1 = s1 >>> F;
      s2 = (s1 & mask) + m_e2; y2 = s2 >>> F;
      s3 = (s2 & mask) + m_e3; y3 = s3 >>> F;
      m_out = y1 + y2 - m_y2d + y3 - 2 * m_y3d1 + m_y3d2;
      m_e1 = s1 & mask; m_e2 = s2 & mask; m_e3 = s3 & mask;
      m_y2d = y2; m_y3d2 = m_y3d1; m_y3d1 = y3;
    end
  endtask

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; smp_en = 1'b0; pcm_in = '0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 1'b0;
    model_reset();
    check("R1 code_out", longint'(code_out), 0);
    check("R1 code_vld", longint'(code_vld), 0);
  endtask

  task automatic step(input string req, input bit en, input longint x);
    smp_en = en;
    pcm_in = IN_W'(x);
    @(posedge clk); #1;
    model_step(en, x);
    check({req, " R2 vld"}, longint'(code_vld), longint'(m_vld));
    check(req, longint'(code_out), m_out);
  endtask

  task automatic dc_run(input longint x, input int n);
    longint acc, diff;
    acc = 0;
    do_reset();
    for (int i = 0; i < n; i++) begin
      step("R6 dc", 1'b1, x);
      acc += longint'(code_out);
    end
    diff = acc * (longint'(1) << F) - longint'(n) * x;
    if (diff < 0) diff = -diff;
    check("R8 dc average", (diff <= 4 * (longint'(1) << F)) ? 1 : 0, 1);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R4 R5 R6: small ramp crossing zero
    for (int i = -40; i < 40; i++) step("R4 ramp", 1'b1, longint'(i) * 123457);
    // R7 full scale both ends
    do_reset();
    for (int i = 0; i < 64; i++) step("R7 max", 1'b1, 64'sd8388607);
    do_reset();
    for (int i = 0; i < 64; i++) step("R7 min", 1'b1, -64'sd8388608);
    do_reset();
    for (int i = 0; i < 64; i++)
      step("R7 alt", 1'b1, (i % 2 == 0) ? 64'sd8388607 : -64'sd8388608);
    // R3 strobe gaps with random data
    do_reset();
    for (int i = 0; i < 3000; i++) begin
      longint x;
      bit en;
      x = longint'($signed(IN_W'($urandom)));
      en = ($urandom % 3) != 0;
      step(en ? "R5 random" : "R3 idle", en, x);
    end
    // R8 DC sweep including extremes
    dc_run(0, 2048);
    dc_run(1, 2048);
    dc_run(-1, 2048);
    dc_run(64'sd2097152 / 3, 4096);
    dc_run(-64'sd5000000, 4096);
    dc_run(64'sd8388607, 4096);
    dc_run(-64'sd8388608, 4096);
    dc_run(64'sd3141592, 4096);
    // R1 reset mid-stream
    step("R6 pre-reset", 1'b1, 64'sd777777);
    do_reset();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule